// File: doc/BRIEF.md
# Multi-Bank SDRAM Command Sequencer

This block sits between a simple memory client and an SDRAM device. The client offers one access at a time on a valid/ready port: a linear address, a read/write flag, write data and two per-access option bits. One bit closes the row once the burst is done. The other shortens an eight-beat burst to four beats. The block splits the address into row, bank and column. It keeps a record of the open row in each of four banks and emits the command sequence the device needs on a synchronous command bus made of chip select, row strobe, column strobe, write enable, bank address and a shared address bus.

An access to a row that is already open goes straight to a READ or WRITE. An access to a closed bank first opens the row. An access to a different row in an open bank first closes that bank. A free-running interval timer asks for a refresh at a fixed period. When the command bus is free, the refresh request wins over client requests: every open bank is closed with one precharge-all, and then REFRESH is sent. Programmable gaps hold off each command until the device timing allows it.

Top module: `sdram_cmd_seq`

## Requirements
- R1: The request address is split as {row, bank, column}: the column is in the low COL_W bits, the 2-bit bank is just above it, and the row is in the top ROW_W bits. An ACTIVATE puts the bank on `ba` and the row on `a`.
- R2: Commands on {cs_n, ras_n, cas_n, we_n} use these codes: ACTIVATE 0011, READ 0101, WRITE 0100, PRECHARGE 0010, REFRESH 0001, and 0111 (NOP) in every other cycle.
- R3: An access to a closed bank issues ACTIVATE, then the READ/WRITE exactly T_RCD cycles later, with the column on a[COL_W-1:0].
- R4: An access whose row is already open in its bank issues only the READ/WRITE, with no ACTIVATE.
- R5: An access to a different row in an open bank issues PRECHARGE of that bank (a[10]=0), then ACTIVATE T_RP cycles later, then the READ/WRITE T_RCD cycles after that.
- R6: Each of the four banks keeps its own open row. Opening one bank does not close another.
- R7: a[10] on a READ/WRITE equals `req_autopre`. When it is set, the bank counts as closed, and the next command follows no sooner than T_BURST+T_RP cycles.
- R8: a[12] on a READ/WRITE is the inverse of `req_chop` (low means a burst of four).
- R9: A refresh becomes pending every T_REFI cycles. REFRESH is issued only with all banks closed: if any bank is open, a PRECHARGE with a[10]=1 comes first and REFRESH follows it T_RP cycles later.
- R10: After REFRESH, no command follows for T_RFC cycles, and every bank counts as closed.
- R11: `req_ready` is high only in the cycle the request's READ/WRITE is decided. That command appears on the bus in the next cycle, with `req_wdata` on `wr_data` for a WRITE. Back-to-back READ/WRITE commands are T_BURST cycles apart.
- R12: During and straight after reset, the bus shows NOP and `req_ready` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Request accepted this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ROW_W+2+COL_W | Linear address {row, bank, column} |
| req_autopre | input | 1 | Close the row after this burst |
| req_chop | input | 1 | Use a burst of four instead of eight |
| req_wdata | input | DATA_W | Write data |
| cs_n | output | 1 | Chip select, active low |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, active low |
| ba | output | 2 | Bank address |
| a | output | ROW_W | Row / column / option address bus |
| wr_data | output | DATA_W | Write data, valid with WRITE |

## Verification
The assertions assume that a requester holds `req_valid` and all request fields steady until `req_ready` is seen. They also assume that the timing parameters are all at least one, that COL_W is no wider than ten bits and that ROW_W is at least thirteen. The directed tasks meet these assumptions. Each task raises one request, waits for acceptance and drops it, and the bench parameters are small positive gaps. The refresh interval is set long enough that the client tests end before the first refresh, so the refresh sequences are observed while the client port is idle.

// File: rtl/sdram_seq_pkg.sv
`timescale 1ns/1ps
// Package: shared command codes and address-bit positions for the
// SDRAM command sequencer. Codes are {cs_n, ras_n, cas_n, we_n}.
package sdram_seq_pkg;
    typedef enum logic [3:0] {
        CMD_REF = 4'b0001,
        CMD_PRE = 4'b0010,
        CMD_ACT = 4'b0011,
        CMD_WR  = 4'b0100,
        CMD_RD  = 4'b0101,
        CMD_NOP = 4'b0111
    } cmd_t;

    localparam int AP_BIT = 10;  // auto-precharge / precharge-all flag
    localparam int BC_BIT = 12;  // burst-chop flag, low = chop
    localparam int BANK_W = 2;
    localparam int NBANK  = 1 << BANK_W;
endpackage

// File: rtl/sdram_gap_timer.sv
`timescale 1ns/1ps
// Module: sdram_gap_timer
// Down-counter that blocks new commands for a loaded number of cycles.
// Assumes load is only asserted while idle is high.
module sdram_gap_timer #(
    parameter int GAP_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [GAP_W-1:0] load_val,
    output logic             idle
);
    logic [GAP_W-1:0] cnt_q;

    // Load a new gap or count the current one down to zero.
    always_ff @(posedge clk) begin
        if (!rst_n)          cnt_q <= '0;
        else if (load)       cnt_q <= load_val;
        else if (cnt_q != 0) cnt_q <= cnt_q - 1'b1;
    end

    assign idle = (cnt_q == '0);
endmodule

// File: rtl/sdram_refresh_timer.sv
`timescale 1ns/1ps
// Module: sdram_refresh_timer
// Free-running interval counter. It raises a pending flag every T_REFI
// cycles, and the flag holds until the sequencer reports a REFRESH.
module sdram_refresh_timer #(
    parameter int T_REFI = 780
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ref_done,
    output logic ref_pend
);
    localparam int CNT_W = $clog2(T_REFI + 1);
    logic [CNT_W-1:0] cnt_q;
    logic             wrap;

    assign wrap = (cnt_q == CNT_W'(T_REFI - 1));

    // Count the interval and wrap at its end.
    always_ff @(posedge clk) begin
        if (!rst_n)    cnt_q <= '0;
        else if (wrap) cnt_q <= '0;
        else           cnt_q <= cnt_q + 1'b1;
    end

    // Raise the pending flag at a wrap and drop it once the refresh is sent.
    always_ff @(posedge clk) begin
        if (!rst_n)        ref_pend <= 1'b0;
        else if (wrap)     ref_pend <= 1'b1;
        else if (ref_done) ref_pend <= 1'b0;
    end
endmodule

// File: rtl/sdram_bank_table.sv
`timescale 1ns/1ps
// Module: sdram_bank_table
// Per-bank open flag and open-row register, plus a lookup that reports
// whether the selected bank has the selected row open.
// Assumes open_en and close_en are never both high.
module sdram_bank_table
    import sdram_seq_pkg::*;
#(
    parameter int ROW_W = 13
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [BANK_W-1:0] sel_bank,
    input  logic [ROW_W-1:0]  sel_row,
    input  logic              open_en,
    input  logic              close_en,
    input  logic              close_all,
    output logic [NBANK-1:0]  open_vec,
    output logic              sel_hit
);
    logic [ROW_W-1:0] row_q [NBANK];

    for (genvar g = 0; g < NBANK; g++) begin : g_bank
        logic is_sel;
        assign is_sel = (sel_bank == BANK_W'(g));

        // Track whether this bank holds an open row.
        always_ff @(posedge clk) begin
            if (!rst_n)                      open_vec[g] <= 1'b0;
            else if (close_all)              open_vec[g] <= 1'b0;
            else if (is_sel && open_en)      open_vec[g] <= 1'b1;
            else if (is_sel && close_en)     open_vec[g] <= 1'b0;
        end

        // Remember which row this bank opened.
        always_ff @(posedge clk) begin
            if (!rst_n)                 row_q[g] <= '0;
            else if (is_sel && open_en) row_q[g] <= sel_row;
        end
    end

    assign sel_hit = open_vec[sel_bank] && (row_q[sel_bank] == sel_row);
endmodule

// File: rtl/sdram_cmd_seq.sv
`timescale 1ns/1ps
// Module: sdram_cmd_seq (top)
// Turns valid/ready memory requests into SDRAM command sequences.
// It keeps an open row per bank and closes all banks before each
// periodic refresh. Assumes requests stay stable until accepted,
// all timing parameters are >= 1, COL_W <= 10 and ROW_W >= 13.
module sdram_cmd_seq
    import sdram_seq_pkg::*;
#(
    parameter int ROW_W   = 13,
    parameter int COL_W   = 10,
    parameter int DATA_W  = 16,
    parameter int T_RCD   = 3,
    parameter int T_RP    = 3,
    parameter int T_RFC   = 10,
    parameter int T_BURST = 4,
    parameter int T_REFI  = 780
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         req_valid,
    output logic                         req_ready,
    input  logic                         req_write,
    input  logic [ROW_W+BANK_W+COL_W-1:0] req_addr,
    input  logic                         req_autopre,
    input  logic                         req_chop,
    input  logic [DATA_W-1:0]            req_wdata,
    output logic                         cs_n,
    output logic                         ras_n,
    output logic                         cas_n,
    output logic                         we_n,
    output logic [BANK_W-1:0]            ba,
    output logic [ROW_W-1:0]             a,
    output logic [DATA_W-1:0]            wr_data
);
    localparam int ADDR_W  = ROW_W + BANK_W + COL_W;
    localparam int GAP_MAX = T_RCD + T_RP + T_RFC + T_BURST;
    localparam int GAP_W   = $clog2(GAP_MAX + 1);

    logic [COL_W-1:0]  col;
    logic [BANK_W-1:0] bnk;
    logic [ROW_W-1:0]  row;
    logic              gap_idle, gap_load;
    logic [GAP_W-1:0]  gap_val;
    logic              ref_pend, ref_done;
    logic [NBANK-1:0]  open_vec;
    logic              sel_hit, open_en, close_en, close_all;
    cmd_t              nxt_cmd, cmd_q;
    logic [BANK_W-1:0] nxt_ba;
    logic [ROW_W-1:0]  nxt_a;

    assign col = req_addr[COL_W-1:0];
    assign bnk = req_addr[COL_W +: BANK_W];
    assign row = req_addr[ADDR_W-1 -: ROW_W];

    sdram_gap_timer #(.GAP_W(GAP_W)) u_gap (
        .clk(clk), .rst_n(rst_n), .load(gap_load), .load_val(gap_val), .idle(gap_idle)
    );

    sdram_refresh_timer #(.T_REFI(T_REFI)) u_ref (
        .clk(clk), .rst_n(rst_n), .ref_done(ref_done), .ref_pend(ref_pend)
    );

    sdram_bank_table #(.ROW_W(ROW_W)) u_tab (
        .clk(clk), .rst_n(rst_n), .sel_bank(bnk), .sel_row(row),
        .open_en(open_en), .close_en(close_en), .close_all(close_all),
        .open_vec(open_vec), .sel_hit(sel_hit)
    );

    // Pick the next command: refresh work first, then the client request.
    always_comb begin
        nxt_cmd   = CMD_NOP;
        nxt_ba    = '0;
        nxt_a     = '0;
        gap_load  = 1'b0;
        gap_val   = '0;
        open_en   = 1'b0;
        close_en  = 1'b0;
        close_all = 1'b0;
        ref_done  = 1'b0;
        req_ready = 1'b0;
        if (gap_idle) begin
            if (ref_pend) begin
                gap_load = 1'b1;
                if (|open_vec) begin
                    nxt_cmd       = CMD_PRE;
                    nxt_a[AP_BIT] = 1'b1;
                    gap_val       = GAP_W'(T_RP - 1);
                    close_all     = 1'b1;
                end else begin
                    nxt_cmd   = CMD_REF;
                    gap_val   = GAP_W'(T_RFC - 1);
                    close_all = 1'b1;
                    ref_done  = 1'b1;
                end
            end else if (req_valid) begin
                nxt_ba   = bnk;
                gap_load = 1'b1;
                if (sel_hit) begin
                    nxt_cmd              = req_write ? CMD_WR : CMD_RD;
                    nxt_a[COL_W-1:0]     = col;
                    nxt_a[AP_BIT]        = req_autopre;
                    nxt_a[BC_BIT]        = ~req_chop;
                    gap_val              = req_autopre ? GAP_W'(T_BURST + T_RP - 1)
                                                       : GAP_W'(T_BURST - 1);
                    close_en             = req_autopre;
                    req_ready            = 1'b1;
                end else if (open_vec[bnk]) begin
                    nxt_cmd  = CMD_PRE;
                    gap_val  = GAP_W'(T_RP - 1);
                    close_en = 1'b1;
                end else begin
                    nxt_cmd  = CMD_ACT;
                    nxt_a    = row;
                    gap_val  = GAP_W'(T_RCD - 1);
                    open_en  = 1'b1;
                end
            end
        end
    end

    // Register the command bus and the write data.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd_q   <= CMD_NOP;
            ba      <= '0;
            a       <= '0;
            wr_data <= '0;
        end else begin
            cmd_q <= nxt_cmd;
            ba    <= nxt_ba;
            a     <= nxt_a;
            if (req_ready && req_write) wr_data <= req_wdata;
        end
    end

    assign {cs_n, ras_n, cas_n, we_n} = cmd_q;
endmodule

// File: rtl/sdram_cmd_seq_chk.sv
`timescale 1ns/1ps
// Module: sdram_cmd_seq_chk
// Protocol checker bound to sdram_cmd_seq. It keeps its own shadow of
// which banks are open and how long ago the last command was issued.
module sdram_cmd_seq_chk
    import sdram_seq_pkg::*;
#(
    parameter int ROW_W = 13,
    parameter int T_RCD = 3,
    parameter int T_RP  = 3,
    parameter int T_RFC = 10
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_ready,
    input logic              cs_n,
    input logic              ras_n,
    input logic              cas_n,
    input logic              we_n,
    input logic [BANK_W-1:0] ba,
    input logic [ROW_W-1:0]  a
);
    logic [3:0]       cmd;
    logic [3:0]       last_q;
    logic [15:0]      since_q;
    logic [NBANK-1:0] shadow_q;
    logic             is_rw;

    assign cmd   = {cs_n, ras_n, cas_n, we_n};
    assign is_rw = (cmd == CMD_RD) || (cmd == CMD_WR);

    // Remember the last command and count the cycles since it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            last_q  <= CMD_NOP;
            since_q <= 16'hFFFF;
        end else if (cmd != CMD_NOP) begin
            last_q  <= cmd;
            since_q <= 16'd1;
        end else if (since_q != 16'hFFFF) begin
            since_q <= since_q + 16'd1;
        end
    end

    // Shadow of the open banks, built from the bus alone.
    always_ff @(posedge clk) begin
        if (!rst_n) shadow_q <= '0;
        else if (cmd == CMD_ACT) shadow_q[ba] <= 1'b1;
        else if (cmd == CMD_PRE && a[AP_BIT]) shadow_q <= '0;
        else if (cmd == CMD_PRE) shadow_q[ba] <= 1'b0;
        else if (is_rw && a[AP_BIT]) shadow_q[ba] <= 1'b0;
    end

    AST_LEGAL_CODE: assert property (@(posedge clk) disable iff (!rst_n)
        cmd inside {CMD_ACT, CMD_RD, CMD_WR, CMD_PRE, CMD_REF, CMD_NOP}); // R2
    AST_ACT_TO_RW: assert property (@(posedge clk) disable iff (!rst_n)
        (is_rw && last_q == CMD_ACT) |-> since_q >= 16'(T_RCD)); // R3
    AST_RW_ON_OPEN: assert property (@(posedge clk) disable iff (!rst_n)
        is_rw |-> shadow_q[ba]); // R4
    AST_PRE_TO_ACT: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd == CMD_ACT && last_q == CMD_PRE) |-> since_q >= 16'(T_RP)); // R5
    AST_ACT_ON_CLOSED: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd == CMD_ACT) |-> !shadow_q[ba]); // R6
    AST_REF_ALL_CLOSED: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd == CMD_REF) |-> shadow_q == '0); // R9
    AST_REF_RECOVERY: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd != CMD_NOP && last_q == CMD_REF) |-> since_q >= 16'(T_RFC)); // R10
    AST_READY_GIVES_RW: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |=> is_rw); // R11
endmodule

bind sdram_cmd_seq sdram_cmd_seq_chk #(
    .ROW_W(ROW_W), .T_RCD(T_RCD), .T_RP(T_RP), .T_RFC(T_RFC)
) u_chk (
    .clk(clk), .rst_n(rst_n), .req_ready(req_ready),
    .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
    .ba(ba), .a(a)
);

// File: tb/sim_sdram_cmd_seq.sv
`timescale 1ns/1ps
// Directed bench for sdram_cmd_seq: one task per scenario.
module sim_sdram_cmd_seq;
    localparam int ROW_W = 13, COL_W = 10, DATA_W = 16;
    localparam int T_RCD = 3, T_RP = 3, T_RFC = 8, T_BURST = 4, T_REFI = 400;
    localparam int ADDR_W = ROW_W + 2 + COL_W;
    localparam logic [3:0] C_ACT = 4'b0011, C_RD = 4'b0101, C_WR = 4'b0100,
                           C_PRE = 4'b0010, C_REF = 4'b0001, C_NOP = 4'b0111;

    logic clk = 0, rst_n = 0;
    logic req_valid = 0, req_ready, req_write = 0, req_autopre = 0, req_chop = 0;
    logic [ADDR_W-1:0] req_addr = '0;
    logic [DATA_W-1:0] req_wdata = '0, wr_data;
    logic cs_n, ras_n, cas_n, we_n;
    logic [1:0] ba;
    logic [ROW_W-1:0] a;

    int checks = 0, errors = 0, cyc = 0, n_log = 0;
    logic [3:0]        lg_cmd [512];
    logic [1:0]        lg_ba  [512];
    logic [ROW_W-1:0]  lg_a   [512];
    logic [DATA_W-1:0] lg_wd  [512];
    int                lg_cyc [512];

    always #5 clk = ~clk;

    sdram_cmd_seq #(.ROW_W(ROW_W), .COL_W(COL_W), .DATA_W(DATA_W), .T_RCD(T_RCD),
        .T_RP(T_RP), .T_RFC(T_RFC), .T_BURST(T_BURST), .T_REFI(T_REFI)) u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_write(req_write), .req_addr(req_addr), .req_autopre(req_autopre),
        .req_chop(req_chop), .req_wdata(req_wdata), .cs_n(cs_n), .ras_n(ras_n),
        .cas_n(cas_n), .we_n(we_n), .ba(ba), .a(a), .wr_data(wr_data));

    // Count cycles and log every non-NOP command away from the edge.
    always @(posedge clk) cyc <= cyc + 1;
    always @(negedge clk) begin
        if (rst_n && {cs_n, ras_n, cas_n, we_n} != C_NOP && n_log < 512) begin
            lg_cmd[n_log] = {cs_n, ras_n, cas_n, we_n};
            lg_ba[n_log]  = ba;
            lg_a[n_log]   = a;
            lg_wd[n_log]  = wr_data;
            lg_cyc[n_log] = cyc;
            n_log = n_log + 1;
        end
    end

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    // Watchdog: counts as a failure and still prints the summary.
    initial begin
        repeat (20000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: actual hung expected done");
        finish_run();
    end

    task automatic chk(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // Offer one request and hold it until accepted.
    task automatic do_req(bit wr, logic [1:0] bk, logic [ROW_W-1:0] rw,
                          logic [COL_W-1:0] cl, bit ap, bit ch, logic [DATA_W-1:0] wd);
        bit got;
        @(negedge clk);
        req_valid = 1; req_write = wr; req_addr = {rw, bk, cl};
        req_autopre = ap; req_chop = ch; req_wdata = wd;
        forever begin
            #1 got = req_ready;
            @(negedge clk);
            if (got) break;
        end
        req_valid = 0;
        repeat (2) @(negedge clk);
    endtask

    function automatic int rw_a(logic [COL_W-1:0] cl, bit ap, bit ch);
        return int'(cl) | (int'(ap) << 10) | (int'(!ch) << 12);
    endfunction

    task automatic t_reset();
        chk("R12 reset bus", int'({cs_n, ras_n, cas_n, we_n}), int'(C_NOP));
        chk("R12 reset ready", int'(req_ready), 0);
        chk("R12 no commands", n_log, 0);
    endtask

    task automatic t_closed_bank();
        int s = n_log;
        do_req(0, 2'd1, 13'h123, 10'h045, 0, 0, '0);
        chk("R3 count", n_log - s, 2);
        chk("R2 R1 act code", int'(lg_cmd[s]), int'(C_ACT));
        chk("R1 act bank", int'(lg_ba[s]), 1);
        chk("R1 act row", int'(lg_a[s]), 'h123);
        chk("R2 read code", int'(lg_cmd[s+1]), int'(C_RD));
        chk("R3 R8 read addr", int'(lg_a[s+1]), rw_a(10'h045, 0, 0));
        chk("R3 act-to-read gap", lg_cyc[s+1] - lg_cyc[s], T_RCD);
    endtask

    task automatic t_page_hit_writes();
        int s = n_log;
        fork
            begin
                do_req(1, 2'd1, 13'h123, 10'h010, 0, 1, 16'hA5A5);
            end
        join
        s = s;
        do_req(1, 2'd1, 13'h123, 10'h011, 0, 1, 16'h5A5A);
        chk("R4 only writes", n_log - s, 2);
        chk("R2 write code", int'(lg_cmd[s]), int'(C_WR));
        chk("R8 chop addr", int'(lg_a[s]), rw_a(10'h010, 0, 1));
        chk("R11 wdata first", int'(lg_wd[s]), 'hA5A5);
        chk("R11 wdata second", int'(lg_wd[s+1]), 'h5A5A);
        chk("R11 burst gap", lg_cyc[s+1] - lg_cyc[s], T_BURST);
    endtask

    task automatic t_two_banks();
        int s = n_log;
        do_req(0, 2'd2, 13'h2F0, 10'h003, 0, 0, '0);
        chk("R6 bank2 act", int'(lg_cmd[s]), int'(C_ACT));
        chk("R6 bank2 ba", int'(lg_ba[s]), 2);
        s = n_log;
        do_req(0, 2'd1, 13'h123, 10'h007, 0, 0, '0);
        chk("R6 bank1 still open", n_log - s, 1);
        chk("R6 bank1 read", int'(lg_cmd[s]), int'(C_RD));
    endtask

    task automatic t_page_miss();
        int s = n_log;
        do_req(0, 2'd1, 13'h0AA, 10'h001, 0, 0, '0);
        chk("R5 count", n_log - s, 3);
        chk("R5 pre code", int'(lg_cmd[s]), int'(C_PRE));
        chk("R5 pre single", int'(lg_a[s][10]), 0);
        chk("R5 pre bank", int'(lg_ba[s]), 1);
        chk("R5 act row", int'(lg_a[s+1]), 'h0AA);
        chk("R5 pre-to-act", lg_cyc[s+1] - lg_cyc[s], T_RP);
        chk("R5 act-to-read", lg_cyc[s+2] - lg_cyc[s+1], T_RCD);
    endtask

    task automatic t_autopre();
        int s = n_log;
        do_req(0, 2'd2, 13'h2F0, 10'h004, 1, 0, '0);
        chk("R7 hit read", n_log - s, 1);
        chk("R7 a10 set", int'(lg_a[s]), rw_a(10'h004, 1, 0));
        do_req(0, 2'd2, 13'h2F0, 10'h005, 0, 0, '0);
        chk("R7 reopen act", int'(lg_cmd[s+1]), int'(C_ACT));
        chk("R7 close gap", lg_cyc[s+1] - lg_cyc[s], T_BURST + T_RP);
    endtask

    task automatic wait_cmd(logic [3:0] code, int from, output int idx);
        idx = -1;
        while (idx < 0) begin
            @(negedge clk); #1;
            for (int i = from; i < n_log; i++)
                if (idx < 0 && lg_cmd[i] == code) idx = i;
        end
    endtask

    task automatic t_refresh();
        int r1, r2, s;
        wait_cmd(C_REF, n_log, r1);
        chk("R9 pre-all before ref", int'(lg_cmd[r1-1]), int'(C_PRE));
        chk("R9 pre-all a10", int'(lg_a[r1-1][10]), 1);
        chk("R9 pre-all gap", lg_cyc[r1] - lg_cyc[r1-1], T_RP);
        s = n_log;
        do_req(0, 2'd1, 13'h0AA, 10'h002, 0, 0, '0);
        chk("R10 rows forgotten", int'(lg_cmd[s]), int'(C_ACT));
        chk("R10 recovery", int'(lg_cyc[s] - lg_cyc[r1] >= T_RFC), 1);
        wait_cmd(C_REF, r1 + 1, r2);
        chk("R9 interval", lg_cyc[r2] - lg_cyc[r1], T_REFI);
        chk("R9 second pre-all", int'(lg_cmd[r2-1]), int'(C_PRE));
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1;
        repeat (2) @(negedge clk);
        t_closed_bank();
        t_page_hit_writes();
        t_two_banks();
        t_page_miss();
        t_autopre();
        t_refresh();
        finish_run();
    end
endmodule